// File: doc/BRIEF.md
# Bus-Written Seven-Segment Digit Store

This block is the processor side of a four-digit seven-segment display driver. A host puts a 4-bit code and a 2-bit digit address on the bus and pulls two active-low selects low together. While both selects are low, the block keeps copying the bus into a capture register. When the write ends, the stored code is decoded into a seven-segment pattern and loaded into the latch of the addressed digit. The write ends when either select rises.

The decoder covers the decimal digits and six extra symbols: dash, E, H, L, P and blank. The four latched patterns are driven out as one flat vector to the display waveform generator. Both selects pass through synchronisers into the single clock domain before any of this logic sees them.

Top module: `seg_bus_digits`

## Requirements
- R1: While both synchronised selects are low, the capture register copies data_i and addr_i on every clock.
- R2: While either select is high, changes on data_i and addr_i have no effect on any displayed digit.
- R3: A write commits exactly once, when the both-low condition ends. This holds whether the selects rise together or one after the other. Bus changes after the first rise, while the other select is still low, do not alter the committed digit.
- R4: The address map is reversed. addr 3 writes digit 1, addr 2 writes digit 2, addr 1 writes digit 3 and addr 0 writes digit 4. Digit k appears on seg_o[7k-1:7k-7].
- R5: Codes 0 to 9 produce the decimal digits. Segment bits are ordered {g,f,e,d,c,b,a} with a at bit 0.
- R6: Codes 10 to 15 produce dash (g only), E (a,d,e,f,g), H (b,c,e,f,g), L (d,e,f), P (a,b,e,f,g) and blank (no segments), in that order.
- R7: After reset, all four digits hold the blank pattern.
- R8: A commit changes only the addressed digit. The other three keep their patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 4 | Character code, bit 0 least significant |
| addr_i | input | 2 | Digit address (reversed map) |
| sel1_ni | input | 1 | Chip select one, active low, asynchronous |
| sel2_ni | input | 1 | Chip select two, active low, asynchronous |
| seg_o | output | 28 | Four latched 7-bit patterns, digit 1 in the low bits |

## Verification
The assertions assume that data_i and addr_i are stable for the synchroniser delay plus one clock before the selects rise. Only then does the capture register hold the intended code at commit. The bench drives the bus at a falling edge and lowers both selects together. It then waits four clocks before releasing either select, so the captured value always matches the driven one. Bus noise is injected only after the first select has risen, or while just one select is low, which is where the design must ignore it.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [SEG_W-1:0] seg_t;

  // {g,f,e,d,c,b,a}
  function automatic seg_t code_to_seg(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:  return 7'h3F;
      4'd1:  return 7'h06;
      4'd2:  return 7'h5B;
      4'd3:  return 7'h4F;
      4'd4:  return 7'h66;
      4'd5:  return 7'h6D;
      4'd6:  return 7'h7D;
      4'd7:  return 7'h07;
      4'd8:  return 7'h7F;
      4'd9:  return 7'h6F;
      4'd10: return 7'h40;
      4'd11: return 7'h79;
      4'd12: return 7'h76;
      4'd13: return 7'h38;
      4'd14: return 7'h73;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/seg_sel_sync.sv
module seg_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel1_ni,
  input  logic sel2_ni,
  output logic both_low_o,
  output logic commit_o
);
  logic [STAGES-1:0] s1_q, s2_q;
  logic low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '1;
      s2_q  <= '1;
      low_q <= 1'b0;
    end else begin
      s1_q  <= {s1_q[STAGES-2:0], sel1_ni};
      s2_q  <= {s2_q[STAGES-2:0], sel2_ni};
      low_q <= both_low_o;
    end
  end

  assign both_low_o = ~s1_q[STAGES-1] & ~s2_q[STAGES-1];
  assign commit_o   = low_q & ~both_low_o;

  // R3
  single_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/seg_in_latch.sv
module seg_in_latch #(
  parameter int CODE_W = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              both_low_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CODE_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '1;
      addr_o <= '0;
    end else if (both_low_i) begin
      data_o <= data_i;
      addr_o <= addr_i;
    end
  end

  // R2
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both_low_i |=> ($stable(data_o) && $stable(addr_o)));
endmodule

// File: rtl/seg_digit_bank.sv
module seg_digit_bank
  import seg_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int ADDR_W     = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        commit_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [CODE_W-1:0]           code_i,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_o
);
  localparam int LAST = NUM_DIGITS - 1;

  logic [ADDR_W-1:0] slot;
  seg_t              pattern;

  // address 0 maps to the highest digit
  assign slot    = ADDR_W'(LAST) - addr_i;
  assign pattern = code_to_seg(code_i);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    seg_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (commit_i && slot == ADDR_W'(g))    q <= pattern;
    end
    assign seg_o[g*SEG_W +: SEG_W] = q;

    // R6
    blank_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && slot == ADDR_W'(g) && code_i == '1) |=> (q == '0));
  end
endmodule

// File: rtl/seg_bus_digits.sv
module seg_bus_digits
  import seg_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [CODE_W-1:0]            data_i,
  input  logic [$clog2(NUM_DIGITS)-1:0] addr_i,
  input  logic                         sel1_ni,
  input  logic                         sel2_ni,
  output logic [NUM_DIGITS*SEG_W-1:0]  seg_o
);
  localparam int ADDR_W = $clog2(NUM_DIGITS);

  logic              both_low, commit;
  logic [CODE_W-1:0] cap_data;
  logic [ADDR_W-1:0] cap_addr;

  seg_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sel1_ni, .sel2_ni,
    .both_low_o(both_low), .commit_o(commit)
  );

  seg_in_latch #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_latch (
    .clk_i, .rst_ni, .both_low_i(both_low),
    .data_i, .addr_i, .data_o(cap_data), .addr_o(cap_addr)
  );

  seg_digit_bank #(.NUM_DIGITS(NUM_DIGITS), .ADDR_W(ADDR_W)) u_bank (
    .clk_i, .rst_ni, .commit_i(commit),
    .addr_i(cap_addr), .code_i(cap_data), .seg_o
  );

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(seg_o));
endmodule

// File: tb/seg_bus_digits_bench.sv
module seg_bus_digits_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  data = '0;
  logic [1:0]  addr = '0;
  logic        sel1 = 1'b1, sel2 = 1'b1;
  logic [27:0] seg;
  logic [6:0]  model [4];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  seg_bus_digits u_seg_bus_digits (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .addr_i(addr),
    .sel1_ni(sel1), .sel2_ni(sel2), .seg_o(seg)
  );

  localparam logic [6:0] A = 7'd1, B = 7'd2, C = 7'd4, D = 7'd8,
                         E = 7'd16, F = 7'd32, G = 7'd64;

  function automatic logic [6:0] want(input int code);
    case (code)
      0: return A|B|C|D|E|F;   1: return B|C;
      2: return A|B|D|E|G;     3: return A|B|C|D|G;
      4: return B|C|F|G;       5: return A|C|D|F|G;
      6: return A|C|D|E|F|G;   7: return A|B|C;
      8: return A|B|C|D|E|F|G; 9: return A|B|C|D|F|G;
      10: return G;            11: return A|D|E|F|G;
      12: return B|C|E|F|G;    13: return D|E|F;
      14: return A|B|E|F|G;    default: return 7'd0;
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (seg[k*7 +: 7] !== model[k]) begin
        errors++;
        $display("FAIL %s digit%0d: got %h expected %h", tag, k+1, seg[k*7 +: 7], model[k]);
      end
    end
  endtask

  // order 0: release together, 1: sel1 first, 2: sel2 first
  task automatic do_write(input int a, input int code, input int order, input string tag);
    @(negedge clk);
    data = 4'(code); addr = 2'(a); sel1 = 0; sel2 = 0;
    repeat (4) @(negedge clk);
    model[3-a] = want(code);
    if (order == 0) begin
      sel1 = 1; sel2 = 1;
      repeat (4) @(negedge clk);
      check_all(tag);
    end else begin
      if (order == 1) sel1 = 1; else sel2 = 1;
      repeat (4) @(negedge clk);
      check_all(tag);
      data = ~data; addr = ~addr;           // R3: noise after the first rise
      repeat (3) @(negedge clk);
      sel1 = 1; sel2 = 1;
      repeat (4) @(negedge clk);
      check_all(tag);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    check_all("R7 reset blank");
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check_all("R7 after release");
    // R4 R5 R6 R8: every code into every address, all release orders
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 16; c++)
        do_write(a, c, (a + c) % 3, (c < 10) ? "R5 R4 R8" : "R6 R4 R8");
    // R4 distinct codes land in mirrored digits
    do_write(3, 1, 0, "R4 addr3");
    do_write(2, 2, 1, "R4 addr2");
    do_write(1, 3, 2, "R4 addr1");
    do_write(0, 4, 0, "R4 addr0");
    // R2: one select low only, bus moving
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      if (s == 0) sel1 = 0; else sel2 = 0;
      for (int v = 0; v < 8; v++) begin
        data = 4'(v + 5); addr = 2'(v);
        @(negedge clk);
      end
      sel1 = 1; sel2 = 1;
      repeat (5) @(negedge clk);
      check_all("R2 single select");
    end
    // R1: bus changes while both low, last value wins
    @(negedge clk);
    data = 4'd7; addr = 2'd0; sel1 = 0; sel2 = 0;
    repeat (4) @(negedge clk);
    data = 4'd12; addr = 2'd2;
    repeat (4) @(negedge clk);
    sel1 = 1; sel2 = 1;
    model[1] = want(12);
    repeat (4) @(negedge clk);
    check_all("R1 follow bus");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule